// File: doc/BRIEF.md
# Transmit Packet Bus Port Demultiplexer

This block sits at the PHY end of a 16-bit transmit packet bus that a link-layer device shares across several logical ports. Each bus word that is qualified by the transfer enable becomes a write into a per-port FIFO. The block produces one write strobe per port, plus a shared data word and shared marker flags that all FIFOs see. Only the FIFO whose strobe is high takes the word. Every output is registered, so a bus word reaches the FIFO side one clock later.

A two-bit mode input sets how the shared strobe pin is read. In packet mode (`01`) the strobe marks a port-select cycle. On such a cycle bits 15:11 of the data word carry the target port number, and the cycle carries no payload. In chunk mode (`10`) the same pin marks the first word of a whole packet, and every write goes to port 0. In the other two codes (`00`, `11`) the pin is ignored, and the bus keeps writing to whatever port was last chosen. An error flag pulses for one cycle when a write cannot be delivered or a port-select names a port that does not exist.

The port selection is held in a small state machine with three states:
- `ST_NONE`: no port chosen since reset.
- `ST_LIVE`: a valid port is held.
- `ST_BAD`: the last select named a port at or above `NUM_PORTS`.

Its transitions are:
- `SEL_OK`: from any state to `ST_LIVE` on a select with a valid address.
- `SEL_BAD`: from any state to `ST_BAD` on a select with an invalid address.
- `HOLD`: otherwise the state stays where it is.

Top module: `txd_port_demux`

## Requirements
- R1: After reset no FIFO write strobe is high, the error flag is low, and the selection state is `ST_NONE`.
- R2: In packet mode, a cycle with enable and strobe both high latches data bits 15:11 as the port number. That cycle produces no FIFO write.
- R3: In packet mode with a valid port held, an enabled non-select word raises only that port's write strobe (bit index = port number) one cycle later. The data word, start-of-packet, end-of-packet and odd-byte flags appear on the shared outputs in the same cycle. The odd-byte flag means only bits 15:8 of the final word are valid.
- R4: A selection stays in force for all later writes until the next select cycle, and a new select redirects the writes that follow it.
- R5: A select with port number at or above `NUM_PORTS` pulses the error flag with no write. Every enabled write after it is dropped with an error pulse until a valid port is selected.
- R6: Enabled writes made before any port has been selected since reset are dropped, each with an error pulse.
- R7: In chunk mode (mode `10`) every enabled word is written to port 0. The shared strobe is forwarded as the packet-start output, and start-of-packet is forwarded as the chunk-start marker. Bits 15:11 do not steer the write, and the held selection is left unchanged.
- R8: In modes `00` and `11` the strobe is ignored. A word with strobe high is written, as ordinary data, to the port currently held, and it does not change the selection.
- R9: A cycle with enable low produces no write and no error pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and FIFO-side clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | 01 packet, 10 chunk, 00/11 strobe ignored |
| bus_en_i | input | 1 | Transfer enable, high qualifies the word |
| bus_data_i | input | 16 | Bus data word; bits 15:11 hold the port on select cycles |
| bus_sop_i | input | 1 | First word of a packet (or of a chunk in chunk mode) |
| bus_eop_i | input | 1 | Last word of a packet |
| bus_odd_i | input | 1 | Final word carries only its upper byte |
| bus_strobe_i | input | 1 | Shared strobe: port-select or packet-start |
| fifo_wr_o | output | NUM_PORTS | One write strobe per port FIFO |
| fifo_data_o | output | 16 | Data word shared by all FIFOs |
| fifo_sop_o | output | 1 | Start-of-packet/chunk marker |
| fifo_eop_o | output | 1 | End-of-packet marker |
| fifo_odd_o | output | 1 | Odd-byte modifier |
| fifo_pstart_o | output | 1 | Whole-packet start marker (chunk mode) |
| err_o | output | 1 | One-cycle protocol error pulse |

## Verification
The hardest case to reach from the ports is the `ST_BAD` state, followed by the recovery out of it. Reaching `ST_BAD` needs a packet-mode select whose upper data bits name a port past `NUM_PORTS`. The bench therefore builds with fewer ports than the 5-bit field can address, issues a select for port 24, sends writes that must be dropped, and then selects a valid port and expects delivery again. The ignored-strobe case needs similar care. A port is selected first in packet mode, the mode is then switched, and a strobe word carrying a different address must still land at the old port.

// File: rtl/txd_pkg.sv
package txd_pkg;
    typedef enum logic [1:0] {
        MODE_PLAIN_A = 2'b00,
        MODE_PACKET  = 2'b01,
        MODE_CHUNK   = 2'b10,
        MODE_PLAIN_B = 2'b11
    } bus_mode_e;

    typedef enum logic [1:0] {
        ST_NONE = 2'd0,
        ST_LIVE = 2'd1,
        ST_BAD  = 2'd2
    } sel_state_e;
endpackage

// File: rtl/txd_sel_fsm.sv
module txd_sel_fsm
    import txd_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int NUM_PORTS = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_cycle_i,
    input  logic [ADDR_W-1:0] sel_addr_i,
    output sel_state_e        state_o,
    output logic [ADDR_W-1:0] port_o,
    output logic              addr_bad_o
);
    localparam int unsigned PORT_LIMIT = NUM_PORTS;

    sel_state_e        state_q, state_d;
    logic [ADDR_W-1:0] port_q, port_d;

    assign addr_bad_o = (32'(sel_addr_i) >= PORT_LIMIT);

    // next-state decode
    always_comb begin
        state_d = state_q;
        port_d  = port_q;
        unique case (state_q)
            ST_NONE, ST_LIVE, ST_BAD: begin
                if (sel_cycle_i && !addr_bad_o) begin
                    state_d = ST_LIVE;        // SEL_OK
                    port_d  = sel_addr_i;
                end else if (sel_cycle_i) begin
                    state_d = ST_BAD;         // SEL_BAD
                end
            end
            default: state_d = ST_NONE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_NONE;
            port_q  <= '0;
        end else begin
            state_q <= state_d;
            port_q  <= port_d;
        end
    end

    assign state_o = state_q;
    assign port_o  = port_q;

    assert_valid_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_cycle_i && !addr_bad_o) |=> (state_q == ST_LIVE && port_q == $past(sel_addr_i)));

    assert_bad_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_cycle_i && addr_bad_o) |=> (state_q == ST_BAD));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_cycle_i |=> ($stable(state_q) && $stable(port_q)));
endmodule

// File: rtl/txd_wr_decode.sv
module txd_wr_decode #(
    parameter int ADDR_W    = 5,
    parameter int NUM_PORTS = 24
) (
    input  logic                 wr_i,
    input  logic [ADDR_W-1:0]    port_i,
    output logic [NUM_PORTS-1:0] wr_vec_o
);
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign wr_vec_o[p] = wr_i && (port_i == ADDR_W'(p));
    end
endmodule

// File: rtl/txd_port_demux.sv
module txd_port_demux
    import txd_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 5,
    parameter int NUM_PORTS = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           mode_i,
    input  logic                 bus_en_i,
    input  logic [DATA_W-1:0]    bus_data_i,
    input  logic                 bus_sop_i,
    input  logic                 bus_eop_i,
    input  logic                 bus_odd_i,
    input  logic                 bus_strobe_i,
    output logic [NUM_PORTS-1:0] fifo_wr_o,
    output logic [DATA_W-1:0]    fifo_data_o,
    output logic                 fifo_sop_o,
    output logic                 fifo_eop_o,
    output logic                 fifo_odd_o,
    output logic                 fifo_pstart_o,
    output logic                 err_o
);
    localparam int ADDR_LSB = DATA_W - ADDR_W;

    bus_mode_e         mode;
    logic              sel_cycle, addr_bad;
    logic [ADDR_W-1:0] sel_addr, cur_port, tgt_port;
    sel_state_e        sel_state;
    logic              wr_d, err_d, pstart_d;
    logic [NUM_PORTS-1:0] wr_vec;

    assign mode      = bus_mode_e'(mode_i);
    assign sel_addr  = bus_data_i[DATA_W-1:ADDR_LSB];
    assign sel_cycle = (mode == MODE_PACKET) && bus_en_i && bus_strobe_i;

    txd_sel_fsm #(.ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_cycle_i(sel_cycle),
        .sel_addr_i (sel_addr),
        .state_o    (sel_state),
        .port_o     (cur_port),
        .addr_bad_o (addr_bad)
    );

    // write / error decision for this bus cycle
    always_comb begin
        wr_d     = 1'b0;
        err_d    = 1'b0;
        pstart_d = 1'b0;
        tgt_port = cur_port;
        if (bus_en_i) begin
            unique case (mode)
                MODE_CHUNK: begin
                    wr_d     = 1'b1;
                    tgt_port = '0;
                    pstart_d = bus_strobe_i;
                end
                MODE_PACKET: begin
                    if (bus_strobe_i) begin
                        err_d = addr_bad;
                    end else if (sel_state == ST_LIVE) begin
                        wr_d = 1'b1;
                    end else begin
                        err_d = 1'b1;
                    end
                end
                MODE_PLAIN_A, MODE_PLAIN_B: begin
                    if (sel_state == ST_LIVE) wr_d = 1'b1;
                    else                      err_d = 1'b1;
                end
                default: ;
            endcase
        end
    end

    txd_wr_decode #(.ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS)) u_dec (
        .wr_i    (wr_d),
        .port_i  (tgt_port),
        .wr_vec_o(wr_vec)
    );

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_wr_o     <= '0;
            fifo_data_o   <= '0;
            fifo_sop_o    <= 1'b0;
            fifo_eop_o    <= 1'b0;
            fifo_odd_o    <= 1'b0;
            fifo_pstart_o <= 1'b0;
            err_o         <= 1'b0;
        end else begin
            fifo_wr_o     <= wr_vec;
            fifo_data_o   <= bus_data_i;
            fifo_sop_o    <= bus_en_i && bus_sop_i;
            fifo_eop_o    <= bus_en_i && bus_eop_i;
            fifo_odd_o    <= bus_en_i && bus_odd_i;
            fifo_pstart_o <= pstart_d;
            err_o         <= err_d;
        end
    end

    assert_onehot_wr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fifo_wr_o));

    assert_select_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_cycle |=> (fifo_wr_o == '0));

    assert_bad_addr_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_cycle && addr_bad) |=> err_o);

    assert_unselected_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en_i && mode != MODE_CHUNK && sel_state != ST_LIVE) |=> (fifo_wr_o == '0));

    assert_chunk_port0_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en_i && mode == MODE_CHUNK) |=> (fifo_wr_o[0] && !err_o));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en_i |=> (fifo_wr_o == '0 && !err_o));
endmodule

// File: tb/test_txd_port_demux.sv
module test_txd_port_demux;
    localparam int NP = 24;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    mode;
    logic          en, sop, eop, odd, stb;
    logic [15:0]   data;
    logic [NP-1:0] wr;
    logic [15:0]   fdata;
    logic          fsop, feop, fodd, fpstart, err;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    txd_port_demux #(.DATA_W(16), .ADDR_W(5), .NUM_PORTS(NP)) i_txd_port_demux (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .bus_en_i(en),
        .bus_data_i(data), .bus_sop_i(sop), .bus_eop_i(eop), .bus_odd_i(odd),
        .bus_strobe_i(stb), .fifo_wr_o(wr), .fifo_data_o(fdata),
        .fifo_sop_o(fsop), .fifo_eop_o(feop), .fifo_odd_o(fodd),
        .fifo_pstart_o(fpstart), .err_o(err)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // drive one bus word at the falling edge, sample after the next rising edge
    task automatic bus(input logic [1:0] m, input logic e, input logic s,
                       input logic [15:0] d, input logic so, input logic eo,
                       input logic od);
        @(negedge clk);
        mode = m; en = e; stb = s; data = d; sop = so; eop = eo; odd = od;
        @(posedge clk);
        #1;
        en = 1'b0; stb = 1'b0; sop = 1'b0; eop = 1'b0; odd = 1'b0;
    endtask

    function automatic logic [31:0] bit_of(input int p);
        return 32'(1) << p;
    endfunction

    function automatic logic [15:0] sel_word(input int p);
        return 16'(p) << 11;
    endfunction

    task automatic t_reset;
        rst_n = 1'b0; mode = 2'b01; en = 0; stb = 0; data = 0; sop = 0; eop = 0; odd = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "wr after reset", 32'(wr), 0);
        chk("R1", "err after reset", 32'(err), 0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_no_select;
        bus(2'b01, 1, 0, 16'hABCD, 1, 0, 0);
        chk("R6", "wr before select", 32'(wr), 0);
        chk("R6", "err before select", 32'(err), 1);
        bus(2'b00, 1, 0, 16'h1111, 0, 0, 0);
        chk("R6", "plain-mode wr before select", 32'(wr), 0);
    endtask

    task automatic t_select_and_write;
        bus(2'b01, 1, 1, sel_word(5), 0, 0, 0);
        chk("R2", "select cycle wr", 32'(wr), 0);
        chk("R2", "select cycle err", 32'(err), 0);
        bus(2'b01, 1, 0, 16'h1234, 1, 0, 0);
        chk("R3", "wr to port 5", 32'(wr), bit_of(5));
        chk("R3", "data", 32'(fdata), 32'h1234);
        chk("R3", "sop", 32'(fsop), 1);
        bus(2'b01, 0, 0, 16'h5555, 0, 0, 0);
        chk("R9", "idle wr", 32'(wr), 0);
        chk("R9", "idle err", 32'(err), 0);
        bus(2'b01, 1, 0, 16'hBE00, 0, 1, 1);
        chk("R4", "held port 5", 32'(wr), bit_of(5));
        chk("R3", "eop", 32'(feop), 1);
        chk("R3", "odd", 32'(fodd), 1);
        chk("R3", "sop low", 32'(fsop), 0);
        bus(2'b01, 1, 1, sel_word(23), 0, 0, 0);
        bus(2'b01, 1, 0, 16'h0F0F, 0, 0, 0);
        chk("R4", "redirect to 23", 32'(wr), bit_of(23));
    endtask

    task automatic t_bad_port;
        bus(2'b01, 1, 1, sel_word(24), 0, 0, 0);
        chk("R5", "bad select err", 32'(err), 1);
        chk("R5", "bad select wr", 32'(wr), 0);
        bus(2'b01, 1, 0, 16'h7777, 0, 0, 0);
        chk("R5", "dropped wr", 32'(wr), 0);
        chk("R5", "dropped err", 32'(err), 1);
        bus(2'b01, 1, 1, sel_word(2), 0, 0, 0);
        chk("R5", "recovery select err", 32'(err), 0);
        bus(2'b01, 1, 0, 16'h2222, 0, 0, 0);
        chk("R5", "recovered wr port 2", 32'(wr), bit_of(2));
    endtask

    task automatic t_chunk;
        bus(2'b10, 1, 1, sel_word(9) | 16'h0042, 1, 0, 0);
        chk("R7", "chunk wr port 0", 32'(wr), bit_of(0));
        chk("R7", "chunk pstart", 32'(fpstart), 1);
        chk("R7", "chunk sop", 32'(fsop), 1);
        chk("R7", "chunk err", 32'(err), 0);
        bus(2'b10, 1, 0, 16'h0043, 0, 1, 0);
        chk("R7", "chunk pstart low", 32'(fpstart), 0);
        chk("R7", "chunk eop", 32'(feop), 1);
        bus(2'b01, 1, 0, 16'h3333, 0, 0, 0);
        chk("R7", "selection kept port 2", 32'(wr), bit_of(2));
    endtask

    task automatic t_plain;
        bus(2'b00, 1, 1, sel_word(7) | 16'h0005, 0, 0, 0);
        chk("R8", "mode00 strobe is data wr", 32'(wr), bit_of(2));
        chk("R8", "mode00 data", 32'(fdata), 32'(sel_word(7) | 16'h0005));
        bus(2'b11, 1, 1, sel_word(11), 0, 0, 0);
        chk("R8", "mode11 strobe is data wr", 32'(wr), bit_of(2));
        bus(2'b01, 1, 0, 16'h4444, 0, 0, 0);
        chk("R8", "selection unchanged", 32'(wr), bit_of(2));
    endtask

    initial begin
        t_reset;
        t_no_select;
        t_select_and_write;
        t_bad_port;
        t_chunk;
        t_plain;
        repeat (2) @(posedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule